// File: doc/BRIEF.md
# Delta-Sigma Converter Read Sequencer

This block sits on the host side of a 24-bit delta-sigma converter. The converter has an active-low conversion-start input, a ready flag that falls when a result is waiting, and a serial data port behind an active-low chip select. On request, the sequencer pulses the start line for a fixed number of clock cycles. It then waits for the ready flag to fall and asserts chip select. It shifts in one result, most significant bit first, and hands the word to the rest of the chip as a one-cycle strobe with a sign- or zero-extended parallel value.

The serial clock comes from one of two sources, chosen per conversion. In the converter-clocked mode the converter drives the serial clock and the sequencer only oversamples it. In the host-clocked mode the sequencer generates the clock itself from its own clock. The sequencer counts every wait in clock cycles, so a converter that never signals ready is reported as a timeout. In host-clocked mode, a result replaced in the middle of a read is reported as an overrun. A continuous setting starts the next conversion as each result is delivered.

The sequencer clock is the converter's master clock, or a faster clock derived from it. All converter outputs (ready, serial clock, data) pass through a two-stage synchronizer before any edge is detected.

Top module: `adc_host_reader`

## Requirements
- R1: During and after reset, until the first request: `conv_n_o` and `cs_n_o` are high, `sclk_o` is low, and `res_valid_o`, `overrun_o` and `timeout_o` are low.
- R2: A high `start_i` in idle drives `conv_n_o` low for exactly CONV_PULSE clock cycles (default 4).
- R3: After the start pulse, `cs_n_o` goes low only once a falling edge of the synchronized ready flag has been detected. It stays low only while bits are being read.
- R4: With `ext_mode_i` = 0 latched at the request, each falling edge of the synchronized `sclk_i` samples one `sdo_i` bit, most significant first, for 24 bits. `sclk_o` stays low throughout.
- R5: With `ext_mode_i` = 1 latched at the request, `sclk_o` runs 24 periods of SCLK_HALF cycles high and SCLK_HALF cycles low, starting low. Data is sampled at each of its falling edges.
- R6: After the 24th bit, `res_valid_o` is high for exactly one cycle with the result, and `cs_n_o` returns high.
- R7: With `bipolar_i` = 1 latched at the request, `res_data_o` (32 bits) holds the 24-bit result with bit 23 copied into bits 31..24. With `bipolar_i` = 0, bits 31..24 are zero.
- R8: When `continuous_i` is high at the cycle the result is delivered, `conv_n_o` is low in the same cycle as `res_valid_o`, and a further result follows.
- R9: In host-clocked mode, a rising edge of the synchronized ready flag before the 24th bit does three things: it abandons the read, raises `cs_n_o`, and pulses `overrun_o` for one cycle with no `res_valid_o`.
- R10: If no ready fall is detected, `timeout_o` pulses for one cycle exactly TMO_LIM (1600+16) cycles after `conv_n_o` fell, and the block returns to idle. If `rdy_i` falls 3 cycles before that limit, the read is still taken; if it falls 2 cycles before, it is not.
- R11: `start_i` is ignored while a conversion or read is in progress; only one start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (converter master clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion (taken in idle) |
| continuous_i | input | 1 | Re-issue a conversion after each result |
| ext_mode_i | input | 1 | 1: host drives serial clock; 0: converter drives it |
| bipolar_i | input | 1 | 1: sign-extend result; 0: zero-extend |
| conv_n_o | output | 1 | Active-low conversion start to converter |
| cs_n_o | output | 1 | Active-low chip select to converter |
| sclk_o | output | 1 | Host-generated serial clock |
| rdy_i | input | 1 | Converter ready flag, falls when data waits |
| sclk_i | input | 1 | Converter-generated serial clock |
| sdo_i | input | 1 | Serial data from converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 32 | Extended result word |
| overrun_o | output | 1 | One-cycle pulse: read abandoned |
| timeout_o | output | 1 | One-cycle pulse: ready never fell |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is delivery of a result and the start of the next conversion in continuous mode. The bench records whether `conv_n_o` is already low in the cycle it sees `res_valid_o`, and expects this exactly once over two back-to-back results. The second pair is the arrival of a ready fall and the expiry of the timeout. A behavioural converter model drops its ready flag at chosen offsets from the start pulse: three cycles before the limit must yield a result, and two cycles before must yield a timeout. The model predicts every result into a queue, and each strobe is compared with the queue head.

// File: rtl/adc_rd_pkg.sv
// Package: shared types of the converter read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rd_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2,
        ST_READ = 2'd3
    } rd_state_e;

endpackage

// File: rtl/rd_sync2.sv
// Module: rd_sync2
// Two-flop synchronizer for a small vector of asynchronous inputs.
// Assumes: each input level lasts at least one clock cycle; RST_VAL
// gives the idle level of each bit so that reset creates no false edge.
module rd_sync2 #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Two capture stages per bit, reset to the bit's idle level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= RST_VAL[g];
                sync_q[g] <= RST_VAL[g];
            end else begin
                meta_q[g] <= d_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/rd_sclk_gen.sv
// Module: rd_sclk_gen
// Host-side serial clock: HALF cycles low, then HALF cycles high, repeated
// while enabled; held low otherwise. fall_o marks the cycle whose closing
// edge brings the clock low, which is the data sampling edge.
// Assumes: HALF >= 3 so that synchronized data is settled before sampling.
module rd_sclk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic fall_o
);

    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] PH_END = HW'(HALF - 1);

    logic [HW-1:0] ph_q;
    logic          sclk_q;

    // Phase counter and clock level
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end else if (ph_q == PH_END) begin
            ph_q   <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            ph_q   <= ph_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign fall_o = en_i && sclk_q && (ph_q == PH_END);

endmodule

// File: rtl/rd_shift_capture.sv
// Module: rd_shift_capture
// Collects serial bits MSB first. last_o flags the sample that completes
// the word; word_o then already includes the incoming bit.
// Assumes: clear_i is held outside a read so each read starts at bit zero.
module rd_shift_capture #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o,
    output logic              last_o
);

    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

    logic [DATA_W-1:0] shift_q;
    logic [CW-1:0]     cnt_q;

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (sample_i) begin
            shift_q <= {shift_q[DATA_W-2:0], bit_i};
            cnt_q   <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    assign word_o = {shift_q[DATA_W-2:0], bit_i};
    assign last_o = sample_i && (cnt_q == LAST_IDX);

    // R4
    cap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && (cnt_q == LAST_IDX) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_host_reader.sv
// Module: adc_host_reader
// Host sequencer for a serial delta-sigma converter: issues the start pulse,
// waits for ready with a timeout, reads one word with either clock source,
// and delivers it as an extended parallel word with a one-cycle strobe.
// Assumes: clk is the converter master clock (or faster, related to it);
// mode and polarity inputs are latched at each request.
module adc_host_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int OUT_W       = 32,
    parameter int CONV_CYCLES = 1600,
    parameter int TMO_MARGIN  = 16,
    parameter int CONV_PULSE  = 4,
    parameter int SCLK_HALF   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             continuous_i,
    input  logic             ext_mode_i,
    input  logic             bipolar_i,
    output logic             conv_n_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    input  logic             rdy_i,
    input  logic             sclk_i,
    input  logic             sdo_i,
    output logic             res_valid_o,
    output logic [OUT_W-1:0] res_data_o,
    output logic             overrun_o,
    output logic             timeout_o
);

    localparam int TMO_LIM = CONV_CYCLES + TMO_MARGIN;
    localparam int CNT_W   = $clog2(TMO_LIM + 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(CONV_PULSE - 1);
    localparam logic [CNT_W-1:0] TMO_END   = CNT_W'(TMO_LIM - 1);

    rd_state_e         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mode_q;
    logic              bip_q;
    logic              valid_q;
    logic [OUT_W-1:0]  data_q;
    logic              ovr_q;
    logic              tmo_q;

    logic [2:0]        raw_in;
    logic [2:0]        syn_in;
    logic              rdy_s, sclk_s, sdo_s;
    logic              rdy_p, sclk_p;
    logic              rdy_fall, rdy_rise, sclk_fall;
    logic              gen_en, gen_fall, sample;
    logic [DATA_W-1:0] word;
    logic              last_bit;

    // Bring converter outputs into the clock domain
    assign raw_in = {rdy_i, sclk_i, sdo_i};

    rd_sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign rdy_s  = syn_in[2];
    assign sclk_s = syn_in[1];
    assign sdo_s  = syn_in[0];

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_p  <= 1'b1;
            sclk_p <= 1'b0;
        end else begin
            rdy_p  <= rdy_s;
            sclk_p <= sclk_s;
        end
    end

    assign rdy_fall  = rdy_p & ~rdy_s;
    assign rdy_rise  = ~rdy_p & rdy_s;
    assign sclk_fall = sclk_p & ~sclk_s;

    // Host clock runs only during a host-clocked read
    assign gen_en = (st_q == ST_READ) && mode_q;

    rd_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (gen_en),
        .sclk_o (sclk_o),
        .fall_o (gen_fall)
    );

    assign sample = (st_q == ST_READ) && (mode_q ? gen_fall : sclk_fall);

    rd_shift_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (st_q != ST_READ),
        .sample_i (sample),
        .bit_i    (sdo_s),
        .word_o   (word),
        .last_o   (last_bit)
    );

    // Extend the raw word per polarity
    function automatic logic [OUT_W-1:0] extend(input logic [DATA_W-1:0] w,
                                                input logic bip);
        logic [OUT_W-1:0] r;
        r = '0;
        r[DATA_W-1:0] = w;
        for (int i = DATA_W; i < OUT_W; i++) r[i] = bip & w[DATA_W-1];
        return r;
    endfunction

    // Sequencer: start pulse, ready wait with timeout, read, deliver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            bip_q   <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
            ovr_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            tmo_q   <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_CONV;
                        cnt_q  <= '0;
                        mode_q <= ext_mode_i;
                        bip_q  <= bipolar_i;
                    end
                end
                ST_CONV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == PULSE_END) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (rdy_fall) begin
                        st_q <= ST_READ;
                    end else if (cnt_q == TMO_END) begin
                        st_q  <= ST_IDLE;
                        tmo_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (mode_q && rdy_rise) begin
                        st_q  <= ST_IDLE;
                        ovr_q <= 1'b1;
                    end else if (last_bit) begin
                        valid_q <= 1'b1;
                        data_q  <= extend(word, bip_q);
                        cnt_q   <= '0;
                        st_q    <= continuous_i ? ST_CONV : ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_n_o    = (st_q != ST_CONV);
    assign cs_n_o      = (st_q != ST_READ);
    assign res_valid_o = valid_q;
    assign res_data_o  = data_q;
    assign overrun_o   = ovr_q;
    assign timeout_o   = tmo_q;

    // R2
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_o) |=> !conv_n_o);

    // R3
    read_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(rdy_fall));

    // R4
    self_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !sclk_o);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R9
    ovr_ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> mode_q && cs_n_o && !res_valid_o);

    // R10
    tmo_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(st_q) == ST_WAIT) && (st_q == ST_IDLE));

endmodule

// File: tb/adc_host_reader_tb_top.sv
// Bench: behavioural converter model plus result queue, compared every clock.
module adc_host_reader_tb_top;

    localparam int TMO_LIM    = 1616;
    localparam int CONV_PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        continuous_i = 1'b0;
    logic        ext_mode_i = 1'b0;
    logic        bipolar_i = 1'b0;
    logic        conv_n_o, cs_n_o, sclk_o;
    logic        rdy_i = 1'b1;
    logic        sclk_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        res_valid_o;
    logic [31:0] res_data_o;
    logic        overrun_o, timeout_o;

    always #5 clk = ~clk;

    adc_host_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .continuous_i(continuous_i),
        .ext_mode_i(ext_mode_i), .bipolar_i(bipolar_i), .conv_n_o(conv_n_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .rdy_i(rdy_i), .sclk_i(sclk_i),
        .sdo_i(sdo_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
        .overrun_o(overrun_o), .timeout_o(timeout_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // converter model state and observation counters
    int          ph = 0;
    int          mcnt = 0;
    int          bitp = 0;
    logic [23:0] cm_word = 24'h0;
    int          cm_delay = 1600;
    bit          cm_respond = 1;
    bit          cm_ovr = 0;
    logic [31:0] expq[$];
    logic [31:0] last_data = 0;
    logic        sclk_o_prev = 0;
    logic        conv_prev = 1;
    int conv_run = 0, last_conv_w = 0, n_conv = 0;
    int n_valid = 0, n_vconv = 0, n_ovr = 0, n_tmo = 0, n_srise = 0;
    int cyc_conv = 0, cyc_tmo = 0;

    function automatic logic [31:0] expect_word(input logic [23:0] w, input bit b);
        return b ? {{8{w[23]}}, w} : {8'h00, w};
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!conv_n_o) conv_run++;
        else if (conv_run != 0) begin last_conv_w = conv_run; conv_run = 0; end
        if (!conv_n_o && conv_prev) n_conv++;
        conv_prev = conv_n_o;
        if (sclk_o && !sclk_o_prev) n_srise++;
        case (ph)
            0: if (rst_n && !conv_n_o) begin ph = 1; mcnt = 0; rdy_i = 1'b1; cyc_conv = cyc; end
            1: begin
                mcnt++;
                if (cm_respond && mcnt == cm_delay) begin rdy_i = 1'b0; ph = 2; bitp = 23; end
            end
            2: if (!cs_n_o) ph = ext_mode_i ? 4 : 3;
            3: begin
                if (!sclk_i) begin sclk_i = 1'b1; sdo_i = cm_word[bitp]; end
                else begin
                    sclk_i = 1'b0;
                    if (bitp == 0) begin expq.push_back(expect_word(cm_word, bipolar_i)); rdy_i = 1'b1; ph = 0; end
                    else bitp--;
                end
            end
            4: begin
                if (sclk_o && !sclk_o_prev) sdo_i = cm_word[bitp];
                else if (!sclk_o && sclk_o_prev) begin
                    if (bitp == 0) begin expq.push_back(expect_word(cm_word, bipolar_i)); rdy_i = 1'b1; ph = 0; end
                    else if (cm_ovr && bitp == 16) begin rdy_i = 1'b1; ph = 0; end
                    else bitp--;
                end
            end
            default: ph = 0;
        endcase
        sclk_o_prev = sclk_o;
        if (res_valid_o) begin
            n_valid++;
            last_data = res_data_o;
            if (!conv_n_o) n_vconv++;
            if (expq.size() == 0) chk(0, "R6 strobe with no result expected", res_data_o, 32'h0);
            else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(res_data_o == e, "R4/R5/R7 result word", res_data_o, e);
            end
        end
        if (overrun_o) n_ovr++;
        if (timeout_o) begin n_tmo++; cyc_tmo = cyc; end
    end

    task automatic clear_counts();
        n_valid = 0; n_vconv = 0; n_ovr = 0; n_tmo = 0; n_srise = 0; n_conv = 0;
    endtask

    task automatic run(input bit ext, input bit bip, input logic [23:0] w,
                       input int dly, input int waitc);
        @(negedge clk);
        ext_mode_i = ext; bipolar_i = bip; cm_word = w; cm_delay = dly;
        clear_counts();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (waitc) @(negedge clk);
    endtask

    task automatic model_reset();
        @(negedge clk);
        ph = 0; rdy_i = 1'b1; sclk_i = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(conv_n_o && cs_n_o, "R1 selects high in reset", {conv_n_o, cs_n_o}, 2'b11);
        chk(!sclk_o && !res_valid_o && !overrun_o && !timeout_o, "R1 outputs low in reset",
            {sclk_o, res_valid_o, overrun_o, timeout_o}, 4'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(conv_n_o && cs_n_o, "R1 idle after reset", {conv_n_o, cs_n_o}, 2'b11);

        // converter-clocked, unipolar
        run(0, 0, 24'hA5C3F1, 1600, 2000);
        chk(last_conv_w == CONV_PULSE, "R2 start pulse width", last_conv_w, CONV_PULSE);
        chk(n_valid == 1, "R6 one strobe per read", n_valid, 1);
        chk(n_srise == 0, "R4 host clock quiet", n_srise, 0);
        chk(cs_n_o == 1'b1, "R3 select released after read", cs_n_o, 1);
        chk(last_data == 32'h00A5C3F1, "R4 MSB-first word", last_data, 32'h00A5C3F1);

        // converter-clocked, bipolar negative
        run(0, 1, 24'h800001, 1600, 2000);
        chk(last_data == 32'hFF800001, "R7 sign extension", last_data, 32'hFF800001);

        // host-clocked, bipolar positive
        run(1, 1, 24'h7FFFFE, 1600, 2000);
        chk(last_data == 32'h007FFFFE, "R7 positive bipolar", last_data, 32'h007FFFFE);
        chk(n_srise == 24, "R5 host clock periods", n_srise, 24);

        // host-clocked, unipolar full scale
        run(1, 0, 24'hFFFFFF, 1600, 2000);
        chk(last_data == 32'h00FFFFFF, "R7 zero extension", last_data, 32'h00FFFFFF);
        chk(n_valid == 1, "R5 host-clocked result", n_valid, 1);

        // continuous: result and next start coincide
        @(negedge clk);
        continuous_i = 1'b1;
        ext_mode_i = 1'b1; bipolar_i = 1'b0; cm_word = 24'h123456; cm_delay = 1600;
        clear_counts();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 4000 && n_valid < 1; i++) @(negedge clk);
        continuous_i = 1'b0;
        repeat (2200) @(negedge clk);
        chk(n_valid == 2, "R8 back-to-back results", n_valid, 2);
        chk(n_vconv == 1, "R8 start in delivery cycle", n_vconv, 1);

        // overrun in host-clocked mode
        cm_ovr = 1;
        run(1, 0, 24'h0F0F0F, 1600, 2000);
        cm_ovr = 0;
        chk(n_ovr == 1, "R9 overrun pulse", n_ovr, 1);
        chk(n_valid == 0, "R9 no result after overrun", n_valid, 0);
        chk(cs_n_o == 1'b1, "R9 select released", cs_n_o, 1);
        model_reset();

        // timeout with silent converter
        cm_respond = 0;
        run(0, 0, 24'h111111, 1600, 2000);
        cm_respond = 1;
        chk(n_tmo == 1, "R10 timeout pulse", n_tmo, 1);
        chk(cyc_tmo - cyc_conv == TMO_LIM, "R10 timeout cycle", cyc_tmo - cyc_conv, TMO_LIM);
        chk(n_valid == 0 && cs_n_o, "R10 no read after timeout", n_valid, 0);
        model_reset();

        // ready fall at the last accepted cycle
        run(0, 0, 24'h5A5A5A, TMO_LIM - 3, 2000);
        chk(n_tmo == 0, "R10 late fall accepted, no timeout", n_tmo, 0);
        chk(n_valid == 1, "R10 late fall accepted, result", n_valid, 1);

        // ready fall one cycle too late
        run(0, 0, 24'h5A5A5A, TMO_LIM - 2, 2000);
        chk(n_tmo == 1, "R10 too-late fall times out", n_tmo, 1);
        chk(n_valid == 0, "R10 too-late fall, no result", n_valid, 0);
        model_reset();

        // starts while busy are ignored
        @(negedge clk);
        ext_mode_i = 1'b0; bipolar_i = 1'b0; cm_word = 24'h00C0DE; cm_delay = 1600;
        clear_counts();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (100) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (1520) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 200 && n_valid < 1; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(n_conv == 1, "R11 single start pulse", n_conv, 1);
        chk(n_valid == 1, "R11 single result", n_valid, 1);
        chk(expq.size() == 0, "R6 every expected result delivered", expq.size(), 0);

        done = 1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

endmodule